// File: doc/BRIEF.md
# Bus-Stall Wait Timer

This block watches a stall condition, normally "the serial clock line is being held low", and reports when it has lasted too long. A free-running prescaler divides the system clock by a power of two. While the stall condition is present and the timer is enabled, a down-counter loaded with a programmed limit moves one step on every prescaled tick. When the counter reaches zero and one more tick arrives, the block emits a single-cycle timeout pulse for the interrupt logic. Further pulses are blocked until the stall condition goes away.

Software sets the block up with two write ports. The control word packs a 15-bit limit together with an enable flag. Because of this packing, software can drop the enable while writing back the same limit, then raise it again, and the count restarts from the full limit. A separate select port chooses the prescale exponent.

Top module: `stall_wait_timer`

## Requirements
- R1: After synchronous reset, `timeout_o` is 0, the enable is 0, the limit is 0x7FFF and the prescale exponent is 0. No pulse appears while the enable stays 0, even with `stall_i` held high.
- R2: `ctrl_wdata[14:0]` is the limit and `ctrl_wdata[15]` is the enable; both are taken when `ctrl_wr` is 1. With prescale exponent 0 and the stall held, the pulse appears limit+1 cycles after the stall begins.
- R3: A `div_wdata` value n from 0 to 14 gives one prescaled tick every 2^n clock cycles. A value of 15 is handled as 14.
- R4: The counter reloads the limit in every cycle in which `stall_i` is 0 or the enable is 0. A stall that ends before expiry produces no pulse, and this holds even when it ends in the very cycle of the expiring tick.
- R5: Clearing the enable and then setting it again with the same limit restarts the count from the full limit.
- R6: Each timeout pulse lasts exactly one cycle. Only one pulse occurs per continuous stall; a new pulse needs `stall_i` to go to 0 first.
- R7: A write to `div_wr` restarts the prescaler phase, so the first tick comes 2^n cycles after the write.
- R8: A limit of 0 with the enable set expires on the first prescaled tick of a stall.
- R9: The largest limit, 0x7FFF, at exponent 0 expires 32768 cycles after the stall begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Bit 15 enable, bits 14:0 limit |
| div_wr | input | 1 | Prescale select write strobe |
| div_wdata | input | 4 | Prescale exponent (15 treated as 14) |
| stall_i | input | 1 | Stall condition, already synchronised |
| timeout_o | output | 1 | One-cycle timeout pulse |

## Verification
Two events can land on the same clock edge: the expiring tick and the end of the stall, and separately a prescale write and a tick. The bench provokes the first by dropping `stall_i` exactly on the cycle that would expire, and the second by writing the prescaler while a stall is running. A behavioural reference model advances once per edge, and the bench compares it with `timeout_o` on every cycle. It also checks pulse counts and latencies derived from the requirements.

// File: rtl/stwt_pkg.sv
package stwt_pkg;
  localparam int CNT_W_DEF   = 15;
  localparam int DIV_W_DEF   = 4;
  localparam int DIV_MAX_DEF = 14;
endpackage

// File: rtl/stwt_prescaler.sv
module stwt_prescaler #(
  parameter int DIV_W   = 4,
  parameter int DIV_MAX = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (DIV_MAX > 0) ? DIV_MAX : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] wrap_at;

  // terminal count is 2^sel - 1, built bit by bit
  always_comb begin
    wrap_at = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(sel)) wrap_at[i] = 1'b1;
    end
  end

  assign tick = (pre_q == wrap_at);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/stwt_stall_counter.sv
module stwt_stall_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             expire_q;
  logic             fire;

  assign fire   = arm && !done_q && tick && (cnt_q == '0);
  assign expire = expire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '1;
      done_q   <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= fire;
      if (!arm) begin
        cnt_q  <= reload_val;
        done_q <= 1'b0;
      end else if (fire) begin
        done_q <= 1'b1;
      end else if (!done_q && tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/stall_wait_timer.sv
module stall_wait_timer #(
  parameter int CNT_W   = stwt_pkg::CNT_W_DEF,
  parameter int DIV_W   = stwt_pkg::DIV_W_DEF,
  parameter int DIV_MAX = stwt_pkg::DIV_MAX_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [CNT_W:0]   ctrl_wdata,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             stall_i,
  output logic             timeout_o
);
  localparam logic [DIV_W-1:0] SEL_MAX = DIV_W'(DIV_MAX);

  logic             cfg_en;
  logic [CNT_W-1:0] cfg_val;
  logic [DIV_W-1:0] div_sel;
  logic             tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en  <= 1'b0;
      cfg_val <= '1;
      div_sel <= '0;
    end else begin
      if (ctrl_wr) begin
        cfg_en  <= ctrl_wdata[CNT_W];
        cfg_val <= ctrl_wdata[CNT_W-1:0];
      end
      if (div_wr) begin
        div_sel <= (div_wdata > SEL_MAX) ? SEL_MAX : div_wdata;
      end
    end
  end

  stwt_prescaler #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (div_wr),
    .sel     (div_sel),
    .tick    (tick)
  );

  stwt_stall_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .arm        (cfg_en && stall_i),
    .tick       (tick),
    .reload_val (cfg_val),
    .expire     (timeout_o)
  );
endmodule

// File: rtl/stwt_checker.sv
module stwt_checker (
  input logic clk,
  input logic rst,
  input logic stall_i,
  input logic en,
  input logic timeout_o
);
  logic fired_in_stall;

  always_ff @(posedge clk) begin
    if (rst || !stall_i) fired_in_stall <= 1'b0;
    else if (timeout_o)  fired_in_stall <= 1'b1;
  end

  assert_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);

  assert_once_per_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (fired_in_stall && stall_i) |=> !timeout_o);

  assert_reload_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (!stall_i || !en) |=> !timeout_o);

  assert_needs_stall_R2: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> $past(stall_i) && $past(en));
endmodule

bind stall_wait_timer stwt_checker u_stwt_checker (
  .clk       (clk),
  .rst       (rst),
  .stall_i   (stall_i),
  .en        (cfg_en),
  .timeout_o (timeout_o)
);

// File: tb/test_stall_wait_timer.sv
module test_stall_wait_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        div_wr = 1'b0;
  logic [3:0]  div_wdata = '0;
  logic        stall_i = 1'b0;
  logic        timeout_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cycles = 0;
  bit comparing = 0;
  string cur_req = "R1";

  // reference model state
  int m_en = 0, m_val = 32'h7FFF, m_div = 0, m_pre = 0, m_cnt = 32'h7FFF;
  int m_done = 0, m_to = 0;

  always #10 clk = ~clk;

  stall_wait_timer i_stall_wait_timer (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .stall_i(stall_i),
    .timeout_o(timeout_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_en = 0; m_val = 32'h7FFF; m_div = 0; m_pre = 0;
      m_cnt = 32'h7FFF; m_done = 0; m_to = 0;
    end else begin
      bit tk;
      bit armed;
      tk = (m_pre == (1 << m_div) - 1);
      armed = (m_en != 0) && stall_i;
      m_to = (armed && !m_done && tk && m_cnt == 0) ? 1 : 0;
      if (!armed) begin
        m_cnt = m_val; m_done = 0;
      end else if (m_to != 0) begin
        m_done = 1;
      end else if (!m_done && tk) begin
        m_cnt = m_cnt - 1;
      end
      if (div_wr) m_pre = 0;
      else if (tk) m_pre = 0;
      else m_pre = m_pre + 1;
      if (ctrl_wr) begin
        m_en = ctrl_wdata[15];
        m_val = ctrl_wdata[14:0];
      end
      if (div_wr) m_div = (div_wdata > 14) ? 14 : div_wdata;
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=still running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    if (comparing) begin
      checks++;
      if (timeout_o !== m_to[0]) begin
        errors++;
        $display("FAIL %s cycle %0d: timeout_o actual=%b expected=%0d",
                 cur_req, cycles, timeout_o, m_to);
      end
      if (timeout_o === 1'b1) pulses++;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input int en, input int val);
    ctrl_wr = 1'b1; ctrl_wdata = {en[0], val[14:0]};
    step();
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_div(input int d);
    div_wr = 1'b1; div_wdata = d[3:0];
    step();
    div_wr = 1'b0;
  endtask

  // steps until a pulse is seen; returns the count, or -1
  task automatic latency(input int limit, output int lat);
    lat = -1;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (timeout_o === 1'b1) begin lat = i; break; end
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    comparing = 1;
    // R1: reset state and disabled timer ignores stall
    step();
    chk("R1 reset timeout", int'(timeout_o), 0);
    stall_i = 1'b1; pulses = 0;
    run(40000);
    chk("R1 no pulse while disabled", pulses, 0);
    stall_i = 1'b0; step();

    // R2: limit 3, exponent 0
    cur_req = "R2";
    wr_div(0); wr_ctrl(1, 3); step();
    stall_i = 1'b1; latency(100, lat);
    chk("R2 latency limit 3", lat, 4);
    // R6: no second pulse in same stall
    cur_req = "R6"; pulses = 0;
    run(50);
    chk("R6 single pulse per stall", pulses, 0);
    stall_i = 1'b0; step(); stall_i = 1'b1;
    latency(100, lat);
    chk("R6 re-arm after stall release", lat, 4);
    stall_i = 1'b0; step();

    // R4: stall ends early, including on the expiring edge
    cur_req = "R4"; wr_ctrl(1, 2); step(); pulses = 0;
    stall_i = 1'b1; run(2); stall_i = 1'b0; run(5);
    chk("R4 stall released on expiring edge", pulses, 0);
    stall_i = 1'b1; run(1); stall_i = 1'b0; run(1); stall_i = 1'b1;
    latency(100, lat);
    chk("R4 reload after short stall", lat, 3);
    stall_i = 1'b0; step();

    // R5: disable and re-enable with the same limit
    cur_req = "R5"; wr_ctrl(1, 5); step();
    stall_i = 1'b1; run(3);
    wr_ctrl(0, 5); wr_ctrl(1, 5);
    latency(100, lat);
    chk("R5 full restart after re-enable", lat, 6);
    stall_i = 1'b0; step();

    // R7 / R8: prescale write resets phase, limit 0 fires on first tick
    cur_req = "R7"; wr_ctrl(1, 0); run(5);
    wr_div(3); stall_i = 1'b1;
    latency(100, lat);
    chk("R7 R8 first tick after prescale write", lat, 8);
    stall_i = 1'b0; step();

    // coincidence: prescale writes during a running stall
    cur_req = "R3"; wr_ctrl(1, 6); stall_i = 1'b1; pulses = 0;
    for (int k = 0; k < 6; k++) begin run(3 + k); wr_div(k % 3); end
    run(300);
    chk("R3 one pulse with prescale writes mid-stall", pulses, 1);
    stall_i = 1'b0; step();

    // R3: exponent 2, limit 1 -> 2 ticks of 4 cycles
    wr_ctrl(1, 1); wr_div(2); stall_i = 1'b1;
    latency(100, lat);
    chk("R3 exponent 2 latency", lat, 8);
    stall_i = 1'b0; step();
    // R3: 15 clamps to 14
    wr_ctrl(1, 0); wr_div(15); stall_i = 1'b1;
    latency(20000, lat);
    chk("R3 exponent 15 treated as 14", lat, 16384);
    stall_i = 1'b0; step();

    // R9: maximum limit
    cur_req = "R9"; wr_div(0); wr_ctrl(1, 32'h7FFF); step();
    stall_i = 1'b1;
    latency(40000, lat);
    chk("R9 max limit latency", lat, 32768);
    stall_i = 1'b0; run(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule